// File: doc/BRIEF.md
# Indexed Block Register Target with Output Gating

This block is a target-only serial register port for a clock fan-out controller. It watches a two-wire bus (clock and data), pulls the data line low through an open-drain enable when it acknowledges or returns data, and never starts a transfer of its own. Its register bank is reached with indexed block transfers. A write carries an offset byte, then a byte count, then that many data bytes. A read is set up by writing only the offset, followed by a repeated START and the read address. The read returns the stored byte count first and then the registers, beginning at the offset.

Register 0 holds one enable bit per clock output. These bits are combined with two pin-level enables, a stop pin and a power-down pin to give each output an enable and a tristate signal. A polarity pin reverses the sense of all four of those pins together. Both bus lines pass through a two-flop synchronizer on a system clock that runs at least 8x the bus clock rate.

Top module: `smb_clk_ctrl`

## Requirements
- R1: The target acknowledges only the 7-bit address 1101110, with the R/W bit following it (0 = write, 1 = read). Any other address is not acknowledged, and the bus is ignored until the next START or STOP.
- R2: In a write, the first byte after the address sets the starting register and the second byte is the count N. The next N data bytes go to consecutive registers, and each of them is acknowledged.
- R3: A write count of zero is not acknowledged. No register is written, and the stored count keeps its previous value.
- R4: Data bytes after the N-th byte of a write are not acknowledged and not written.
- R5: A read addressed after an offset-only write returns the stored count first, then registers from that offset onward, until the master NACKs a byte. The stored count resets to 4.
- R6: Four registers are implemented, at offsets 0 to 3. The index wraps from 3 to 0. Bytes written to offsets of 4 or above are acknowledged and then dropped, and the index wraps to 0 after them. Reads of those offsets return 0x00.
- R7: A repeated START at any point returns the target to address decoding. Data bytes already acknowledged stay written.
- R8: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. After either one, the target has released SDA.
- R9: The target changes its SDA drive only while SCL is low.
- R10: Register 0 bits [3:0] enable outputs 0 to 3. Register 0 resets to 0x0F and the other registers reset to 0x00.
- R11: While the stop pin or the power-down pin is at its active level (low when not inverted), all four outputs are disabled.
- R12: Output 0 also requires en_first_i and output 3 also requires en_last_i, each active high when not inverted.
- R13: When pol_inv_i is high, the sense of en_first_i, en_last_i, halt_i and sleep_i is reversed.
- R14: out_hiz_o is the bitwise complement of out_en_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain) |
| en_first_i | input | 1 | Pin enable for output 0 |
| en_last_i | input | 1 | Pin enable for output 3 |
| halt_i | input | 1 | Stop pin, active low unless inverted |
| sleep_i | input | 1 | Power-down pin, active low unless inverted |
| pol_inv_i | input | 1 | Reverses the sense of the four control pins |
| out_en_o | output | 4 | Per-output enable |
| out_hiz_o | output | 4 | Per-output tristate |

## Verification
A wrong protocol state appears on SDA within the byte where it happens. An ACK is missing or extra in the ninth clock, or the byte returned during a read differs. Index and count errors show up on the next read-back, as a wrong count byte or as data from the wrong register. The output gating is combinational from its pins, so a fault there is visible in the same cycle on out_en_o and out_hiz_o.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_OFFS, ST_CNT, ST_WDATA, ST_RDATA, ST_SKIP
  } smb_st_e;
endpackage

// File: rtl/smb_sync.sv
module smb_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_d  <= scl_ff[1];
      sda_d  <= sda_ff[1];
    end
  end

  assign scl_o      = scl_ff[1];
  assign sda_o      = sda_ff[1];
  assign scl_rise_o = scl_ff[1] & ~scl_d;
  assign scl_fall_o = ~scl_ff[1] & scl_d;
  assign start_o    = scl_ff[1] & scl_d & sda_d & ~sda_ff[1];
  assign stop_o     = scl_ff[1] & scl_d & ~sda_d & sda_ff[1];
endmodule

// File: rtl/smb_target.sv
module smb_target
  import smb_pkg::*;
#(
  parameter logic [6:0] ADDR     = 7'b1101110,
  parameter int         NUM_REGS = 4,
  parameter int         N_OUT    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  output logic [N_OUT-1:0] en_bits_o
);
  localparam int         IW     = $clog2(NUM_REGS);
  localparam logic [7:0] LAST   = 8'(NUM_REGS - 1);
  localparam logic [7:0] R0_RST = 8'((1 << N_OUT) - 1);

  smb_st_e    state_q;
  logic [3:0] bit_q;
  logic [7:0] sh_q, tx_q, base_q, idx_q, cnt_q, rem_q;
  logic       ack_ph_q, first_q;
  logic [7:0] regs_q [NUM_REGS];
  logic [7:0] rd_b, nxt_b;
  logic       rx_st;

  function automatic logic [7:0] step(input logic [7:0] i);
    return (i >= LAST) ? 8'd0 : i + 8'd1;
  endfunction

  always_comb begin
    rd_b  = (idx_q <= LAST) ? regs_q[idx_q[IW-1:0]] : 8'h00;
    nxt_b = first_q ? cnt_q : rd_b;
    rx_st = (state_q == ST_ADDR) || (state_q == ST_OFFS) ||
            (state_q == ST_CNT)  || (state_q == ST_WDATA);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      bit_q    <= '0;
      sh_q     <= '0;
      tx_q     <= '0;
      base_q   <= '0;
      idx_q    <= '0;
      cnt_q    <= 8'(NUM_REGS);
      rem_q    <= '0;
      ack_ph_q <= 1'b0;
      first_q  <= 1'b0;
      sda_oe_o <= 1'b0;
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= (i == 0) ? R0_RST : 8'h00;
    end else if (start_i) begin
      state_q  <= ST_ADDR;
      bit_q    <= '0;
      ack_ph_q <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (stop_i) begin
      state_q  <= ST_IDLE;
      ack_ph_q <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (state_q == ST_RDATA) begin
      if (scl_rise_i && bit_q != 4'd8) begin
        bit_q <= bit_q + 4'd1;
      end else if (scl_rise_i && !ack_ph_q) begin
        // master NACK ends the read
        if (sda_i) state_q <= ST_SKIP;
        else       ack_ph_q <= 1'b1;
      end
      if (scl_fall_i) begin
        if (ack_ph_q) begin
          ack_ph_q <= 1'b0;
          bit_q    <= '0;
          tx_q     <= nxt_b;
          sda_oe_o <= ~nxt_b[7];
          if (first_q) first_q <= 1'b0;
          else         idx_q   <= step(idx_q);
        end else if (bit_q == 4'd8) begin
          sda_oe_o <= 1'b0;
        end else if (bit_q != 4'd0) begin
          sda_oe_o <= ~tx_q[6];
          tx_q     <= {tx_q[6:0], 1'b0};
        end
      end
    end else if (rx_st) begin
      if (scl_rise_i && bit_q != 4'd8) begin
        sh_q  <= {sh_q[6:0], sda_i};
        bit_q <= bit_q + 4'd1;
      end
      if (scl_fall_i) begin
        if (ack_ph_q) begin
          ack_ph_q <= 1'b0;
          sda_oe_o <= 1'b0;
          bit_q    <= '0;
        end else if (bit_q == 4'd8) begin
          ack_ph_q <= 1'b1;
          sda_oe_o <= 1'b1;
          unique case (state_q)
            ST_ADDR: begin
              if (sh_q[7:1] != ADDR) begin
                ack_ph_q <= 1'b0;
                sda_oe_o <= 1'b0;
                state_q  <= ST_SKIP;
              end else if (sh_q[0]) begin
                state_q <= ST_RDATA;
                idx_q   <= base_q;
                first_q <= 1'b1;
              end else begin
                state_q <= ST_OFFS;
              end
            end
            ST_OFFS: begin
              base_q  <= sh_q;
              idx_q   <= sh_q;
              state_q <= ST_CNT;
            end
            ST_CNT: begin
              if (sh_q == 8'd0) begin
                ack_ph_q <= 1'b0;
                sda_oe_o <= 1'b0;
                state_q  <= ST_SKIP;
              end else begin
                cnt_q   <= sh_q;
                rem_q   <= sh_q;
                state_q <= ST_WDATA;
              end
            end
            default: begin
              if (rem_q == 8'd0) begin
                ack_ph_q <= 1'b0;
                sda_oe_o <= 1'b0;
                state_q  <= ST_SKIP;
              end else begin
                if (idx_q <= LAST) regs_q[idx_q[IW-1:0]] <= sh_q;
                idx_q <= step(idx_q);
                rem_q <= rem_q - 8'd1;
              end
            end
          endcase
        end
      end
    end
  end

  assign en_bits_o = regs_q[0][N_OUT-1:0];
endmodule

// File: rtl/smb_out_gate.sv
module smb_out_gate #(
  parameter int N_OUT = 4
) (
  input  logic [N_OUT-1:0] en_bits_i,
  input  logic             en_first_i,
  input  logic             en_last_i,
  input  logic             halt_i,
  input  logic             sleep_i,
  input  logic             pol_inv_i,
  output logic [N_OUT-1:0] out_en_o,
  output logic [N_OUT-1:0] out_hiz_o
);
  logic first_ok, last_ok, kill;

  assign first_ok = en_first_i ^ pol_inv_i;
  assign last_ok  = en_last_i ^ pol_inv_i;
  assign kill     = ~(halt_i ^ pol_inv_i) | ~(sleep_i ^ pol_inv_i);

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    logic pin_ok;
    if (k == 0)              assign pin_ok = first_ok;
    else if (k == N_OUT - 1) assign pin_ok = last_ok;
    else                     assign pin_ok = 1'b1;
    assign out_en_o[k]  = en_bits_i[k] & pin_ok & ~kill;
    assign out_hiz_o[k] = ~out_en_o[k];
  end
endmodule

// File: rtl/smb_clk_ctrl.sv
module smb_clk_ctrl #(
  parameter logic [6:0] ADDR     = 7'b1101110,
  parameter int         NUM_REGS = 4,
  parameter int         N_OUT    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic             en_first_i,
  input  logic             en_last_i,
  input  logic             halt_i,
  input  logic             sleep_i,
  input  logic             pol_inv_i,
  output logic [N_OUT-1:0] out_en_o,
  output logic [N_OUT-1:0] out_hiz_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic [N_OUT-1:0] en_bits;

  smb_sync u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_p), .stop_o(stop_p)
  );

  smb_target #(.ADDR(ADDR), .NUM_REGS(NUM_REGS), .N_OUT(N_OUT)) u_target (
    .clk_i, .rst_ni, .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_p), .stop_i(stop_p), .sda_i(sda_s),
    .sda_oe_o, .en_bits_o(en_bits)
  );

  smb_out_gate #(.N_OUT(N_OUT)) u_gate (
    .en_bits_i(en_bits), .en_first_i, .en_last_i, .halt_i, .sleep_i, .pol_inv_i,
    .out_en_o, .out_hiz_o
  );
endmodule

// File: rtl/smb_clk_ctrl_chk.sv
module smb_clk_ctrl_chk #(
  parameter int N_OUT = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_s_i,
  input logic             start_i,
  input logic             stop_i,
  input logic             sda_oe_i,
  input logic             en_first_i,
  input logic             en_last_i,
  input logic             halt_i,
  input logic             sleep_i,
  input logic             pol_inv_i,
  input logic [N_OUT-1:0] out_en_i,
  input logic [N_OUT-1:0] out_hiz_i
);
  // R9
  sda_drive_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> !scl_s_i);

  // R8
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_i);

  // R8
  start_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !sda_oe_i);

  // R11
  halt_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol_inv_i ? halt_i : !halt_i) |-> (out_en_i == '0));

  // R11
  sleep_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol_inv_i ? sleep_i : !sleep_i) |-> (out_en_i == '0));

  // R12
  first_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol_inv_i ? en_first_i : !en_first_i) |-> !out_en_i[0]);

  // R12
  last_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol_inv_i ? en_last_i : !en_last_i) |-> !out_en_i[N_OUT-1]);

  // R14
  hiz_compl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_hiz_i == ~out_en_i);
endmodule

bind smb_clk_ctrl smb_clk_ctrl_chk #(.N_OUT(N_OUT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .start_i(start_p), .stop_i(stop_p),
  .sda_oe_i(sda_oe_o), .en_first_i(en_first_i), .en_last_i(en_last_i),
  .halt_i(halt_i), .sleep_i(sleep_i), .pol_inv_i(pol_inv_i),
  .out_en_i(out_en_o), .out_hiz_i(out_hiz_o)
);

// File: tb/smb_clk_ctrl_tb.sv
module smb_clk_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;
  localparam logic [6:0] DEV = 7'b1101110;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_bus;
  logic en_first = 1'b1, en_last = 1'b1, halt = 1'b1, sleep = 1'b1, pinv = 1'b0;
  logic [3:0] out_en, out_hiz;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] model [4];
  logic [7:0] cnt_m;
  logic [7:0] wbuf [8];

  always #(CLK_PERIOD / 2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  smb_clk_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .en_first_i(en_first), .en_last_i(en_last), .halt_i(halt), .sleep_i(sleep),
    .pol_inv_i(pinv), .out_en_o(out_en), .out_hiz_o(out_hiz)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1); sda_m = 1'b0; wq(1); scl_m = 1'b0; wq(1);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(1); scl_m = 1'b1; wq(1); sda_m = 1'b1; wq(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(1);
    end
    sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1); ack = ~sda_bus; wq(1); scl_m = 1'b0; wq(1);
  endtask

  task automatic recv_byte(input logic last, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(1); scl_m = 1'b1; wq(1); b[i] = sda_bus; wq(1); scl_m = 1'b0;
    end
    wq(1); sda_m = last; wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(1); sda_m = 1'b1;
  endtask

  function automatic logic [7:0] nidx(input logic [7:0] i);
    return (i >= 8'd3) ? 8'd0 : i + 8'd1;
  endfunction

  function automatic logic [3:0] gate_exp(input logic [3:0] r, input logic f, input logic l,
                                          input logic h, input logic s, input logic p);
    logic on;
    logic [3:0] e;
    on = p ? (!h && !s) : (h && s);
    e = on ? r : 4'h0;
    if (p ? f : !f) e[0] = 1'b0;
    if (p ? l : !l) e[3] = 1'b0;
    return e;
  endfunction

  // write: offset, count, then nsend bytes from wbuf
  task automatic do_write(input logic [7:0] off, input logic [7:0] cnt, input int nsend, input string req);
    logic ack;
    logic [7:0] ix;
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk(ack, "R1 addr ack", ack, 1);
    send_byte(off, ack);         chk(ack, "R2 offset ack", ack, 1);
    send_byte(cnt, ack);         chk(ack == (cnt != 0), "R3 count ack", ack, cnt != 0);
    if (cnt != 0) cnt_m = cnt;
    ix = off;
    for (int i = 0; i < nsend; i++) begin
      send_byte(wbuf[i], ack);
      chk(ack == (cnt != 0 && i < cnt), {req, " data ack"}, ack, (cnt != 0 && i < cnt));
      if (cnt != 0 && i < cnt) begin
        if (ix < 4) model[ix[1:0]] = wbuf[i];
        ix = nidx(ix);
      end
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] off, input int n, input string req);
    logic ack;
    logic [7:0] b, ix;
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk(ack, "R1 addr ack", ack, 1);
    send_byte(off, ack);         chk(ack, "R5 offset ack", ack, 1);
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk(ack, "R5 read addr ack", ack, 1);
    recv_byte(n == 0, b);        chk(b == cnt_m, "R5 count byte", b, cnt_m);
    ix = off;
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, b);
      chk(b == ((ix < 4) ? model[ix[1:0]] : 8'h00), req, b, (ix < 4) ? model[ix[1:0]] : 8'h00);
      ix = nidx(ix);
    end
    bus_stop();
    wq(1);
    chk(sda_oe == 1'b0, "R8 released after stop", sda_oe, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] off, cnt;
    logic [3:0] e;
    void'($urandom(32'd1234));
    model[0] = 8'h0F; model[1] = 8'h00; model[2] = 8'h00; model[3] = 8'h00;
    cnt_m = 8'd4;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10 R14 reset state
    chk(sda_oe == 1'b0, "R10 reset sda", sda_oe, 0);
    chk(out_en == 4'hF, "R10 reset enables", out_en, 4'hF);
    chk(out_hiz == 4'h0, "R14 reset hiz", out_hiz, 4'h0);
    do_read(8'd0, 4, "R10 reset regs");

    // R2 R6 random block writes with read-back
    for (int t = 0; t < 8; t++) begin
      off = 8'($urandom % 6);
      cnt = 8'(1 + $urandom % 4);
      for (int i = 0; i < 8; i++) wbuf[i] = 8'($urandom);
      do_write(off, cnt, int'(cnt), "R2 write");
      do_read(off, int'(cnt), "R6 readback");
    end

    // R6 wrap from 3 to 0
    wbuf[0] = 8'h31; wbuf[1] = 8'h0A; wbuf[2] = 8'h05;
    do_write(8'd3, 8'd3, 3, "R6 wrap");
    chk(model[0] == 8'h0A && model[1] == 8'h05, "R6 wrap model", model[0], 8'h0A);
    do_read(8'd3, 4, "R6 wrap readback");

    // R6 unimplemented offset, then wrap to 0
    wbuf[0] = 8'hEE; wbuf[1] = 8'h07;
    do_write(8'd5, 8'd2, 2, "R6 unimpl");
    do_read(8'd5, 2, "R6 unimpl read");

    // R1 wrong address
    bus_start();
    send_byte({7'b1101111, 1'b0}, ack); chk(!ack, "R1 wrong addr nack", ack, 0);
    send_byte(8'h00, ack);              chk(!ack, "R1 ignored byte", ack, 0);
    send_byte(8'h01, ack);              chk(!ack, "R1 ignored byte", ack, 0);
    bus_stop();
    do_read(8'd0, 4, "R1 regs unchanged");

    // R3 zero count
    wbuf[0] = 8'h99;
    do_write(8'd1, 8'd0, 1, "R3 zero count");
    do_read(8'd1, 2, "R3 no write");

    // R4 beyond count
    wbuf[0] = 8'h3C; wbuf[1] = 8'hC3;
    do_write(8'd2, 8'd1, 2, "R4 beyond count");
    do_read(8'd2, 2, "R4 readback");

    // R7 repeated start after one committed byte
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk(ack, "R7 addr", ack, 1);
    send_byte(8'd1, ack);        chk(ack, "R7 offset", ack, 1);
    send_byte(8'd3, ack);        chk(ack, "R7 count", ack, 1);
    send_byte(8'hA5, ack);       chk(ack, "R7 data", ack, 1);
    model[1] = 8'hA5; cnt_m = 8'd3;
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk(ack, "R7 readdr after rs", ack, 1);
    recv_byte(1'b0, off);        chk(off == 8'd3, "R7 count byte", off, 3);
    recv_byte(1'b0, off);        chk(off == 8'hA5, "R7 committed", off, 8'hA5);
    recv_byte(1'b1, off);        chk(off == model[2], "R7 untouched", off, model[2]);
    bus_stop();

    // R10-R14 gating, random pins and register 0
    for (int t = 0; t < 80; t++) begin
      if (t % 20 == 0) begin
        wbuf[0] = 8'($urandom);
        do_write(8'd0, 8'd1, 1, "R10 reg0");
      end
      en_first = 1'($urandom); en_last = 1'($urandom);
      halt = ($urandom % 4) != 0; sleep = ($urandom % 4) != 0; pinv = 1'($urandom);
      if (pinv) begin halt = ~halt; sleep = ~sleep; end
      @(negedge clk); @(negedge clk);
      e = gate_exp(model[0][3:0], en_first, en_last, halt, sleep, pinv);
      chk(out_en == e, "R11 R12 R13 gate", out_en, e);
      chk(out_hiz == ~e, "R14 hiz", out_hiz, ~e);
    end

    // R13 directed: inverted, all pins low, enables from reg0
    wbuf[0] = 8'h0F;
    do_write(8'd0, 8'd1, 1, "R10 reg0");
    pinv = 1'b1; en_first = 1'b0; en_last = 1'b0; halt = 1'b0; sleep = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(out_en == 4'hF, "R13 inverted all on", out_en, 4'hF);
    sleep = 1'b1;
    @(negedge clk);
    chk(out_en == 4'h0, "R11 inverted sleep", out_en, 4'h0);
    pinv = 1'b0; en_first = 1'b1; en_last = 1'b0; halt = 1'b1; sleep = 1'b1;
    @(negedge clk);
    chk(out_en == 4'h7, "R12 last pin off", out_en, 4'h7);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule